// File: doc/BRIEF.md
# Board Interrupt Expander with Identification Registers

This block is a small register file that sits on a 16-bit synchronous host bus inside a board-support logic device. It gathers up to sixteen interrupt request inputs from peripherals on the board, which are an Ethernet controller, two external UARTs and two push buttons, with the remaining lines spare. Each input is captured into a sticky status bit. A per-line mask selects which captured bits may pull the single active-low, level-sensitive interrupt output to the host low.

Host software services the pending lines from bit 0 upward, so a bit's position is its source number. To acknowledge a line, software writes a one at that bit of the acknowledge register and then writes zero to the same register. The status bit is held cleared while the acknowledge bit is one.

At start-up the host reads three fixed signature words and decides from them whether the board is fitted. It then reads a version word and a board identity word, which are both parameters. An LED register and a module-reset register are plain read/write words that drive output pins.

Top module: `cpld_irq_hub`

## Requirements
- R1: Reads return the signature words 0xAAAA at byte offset 0x40, 0x5555 at 0x48 and 0xCAFE at 0x58. Reads return the VERSION parameter at 0x50 and the BOARD_ID parameter at 0x68.
- R2: After synchronous reset the mask register (0x38) reads 0xFFFF. The status (0x10), acknowledge (0x20), LED (0x00) and module-reset (0x60) registers read 0. `irq_n` is high, and `led_out` and `mod_rst_out` are 0.
- R3: Status bit i, read at 0x10, becomes 1 within six clock cycles once `irq_src[i]` is held high. It stays 1 after the source falls, until it is acknowledged. Bit position i equals source line i.
- R4: While bit i of the acknowledge register (0x20) is 1, status bit i reads 0, even with its source high. When the bit returns to 0 and the source is still high, status bit i sets again. Writing 0xFFFF and then 0 clears every status bit.
- R5: A 1 in mask bit i disables line i and a 0 enables it. `irq_n` is low exactly when some status bit is 1 with its mask bit 0, and high otherwise, within three cycles of a change.
- R6: A read issued with `bus_rd` in one cycle updates `bus_rdata` at the next rising edge. `bus_rdata` holds its value while `bus_rd` is low.
- R7: The LED register (0x00) and the module-reset register (0x60) read back what was written and drive `led_out` and `mod_rst_out`. The acknowledge register (0x20) and the mask register (0x38) also read back what was written.
- R8: Writes to read-only offsets (0x10, 0x40, 0x48, 0x50, 0x58, 0x68) and to unmapped offsets, odd ones included, change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_src | input | LINES | Peripheral interrupt requests, asynchronous, active high |
| irq_n | output | 1 | Interrupt to the host, active low, level |
| led_out | output | DATA_W | LED register contents |
| mod_rst_out | output | DATA_W | Module-reset register contents |

## Verification
The bench builds the block with its defaults of sixteen lines, 16-bit data and an 8-bit address. It sets VERSION to 0x0102 and BOARD_ID to 0x3C51, so that these two values differ from every other register. The 8-bit address space is small enough to sweep completely: the bench first writes 0xFFFF to every offset that must not accept it and then reads all 256 offsets against a bench model. Each of the sixteen lines is driven alone through capture, masking, sticky hold, acknowledge-while-active and re-capture, and a multi-line pattern checks that the output tracks only the unmasked lines.

// File: rtl/cih_pkg.sv
package cih_pkg;

  localparam logic [7:0] OFS_LED    = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_ACK    = 8'h20;
  localparam logic [7:0] OFS_MASK   = 8'h38;
  localparam logic [7:0] OFS_SIG_A  = 8'h40;
  localparam logic [7:0] OFS_SIG_B  = 8'h48;
  localparam logic [7:0] OFS_VER    = 8'h50;
  localparam logic [7:0] OFS_SIG_C  = 8'h58;
  localparam logic [7:0] OFS_MODRST = 8'h60;
  localparam logic [7:0] OFS_BID    = 8'h68;

  localparam logic [15:0] SIG_A_VAL = 16'hAAAA;
  localparam logic [15:0] SIG_B_VAL = 16'h5555;
  localparam logic [15:0] SIG_C_VAL = 16'hCAFE;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LED,
    SEL_STATUS,
    SEL_ACK,
    SEL_MASK,
    SEL_SIG_A,
    SEL_SIG_B,
    SEL_VER,
    SEL_SIG_C,
    SEL_MODRST,
    SEL_BID
  } reg_sel_e;

endpackage

// File: rtl/cih_sync.sv
module cih_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= din[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign dout = stage2_q;

endmodule

// File: rtl/cih_irq_core.sv
module cih_irq_core #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] level,
  input  logic [LINES-1:0] ack_bits,
  input  logic [LINES-1:0] mask_bits,
  output logic [LINES-1:0] status,
  output logic             irq_n
);

  logic [LINES-1:0] status_q;
  logic [LINES-1:0] live;
  logic             irq_n_q;

  assign live = status_q & ~mask_bits;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)              status_q[i] <= 1'b0;
      else if (ack_bits[i]) status_q[i] <= 1'b0;
      else if (level[i])    status_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~(|live);
  end

  assign status = status_q;
  assign irq_n  = irq_n_q;

  // R4: an acknowledged line reads zero in the following cycle
  p_ack_holds_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_bits != '0) |=> ((status_q & $past(ack_bits)) == '0));

  // R3: a captured bit survives unless it was acknowledged
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ((($past(status_q) & ~$past(ack_bits)) & ~status_q) == '0));

  // R5: with every line masked the output stays high
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_bits) == {LINES{1'b1}}) |-> irq_n_q);

endmodule

// File: rtl/cih_regfile.sv
module cih_regfile
  import cih_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 8,
  parameter int              LINES    = 16,
  parameter logic [15:0]     VERSION  = 16'h0001,
  parameter logic [15:0]     BOARD_ID = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  status,
  output logic [LINES-1:0]  ack_bits,
  output logic [LINES-1:0]  mask_bits,
  output logic [DATA_W-1:0] led,
  output logic [DATA_W-1:0] mod_rst
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] led_q;
  logic [DATA_W-1:0] modrst_q;
  logic [LINES-1:0]  ack_q;
  logic [LINES-1:0]  mask_q;

  always_comb begin
    sel = SEL_NONE;
    case (bus_addr)
      ADDR_W'(OFS_LED):    sel = SEL_LED;
      ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
      ADDR_W'(OFS_ACK):    sel = SEL_ACK;
      ADDR_W'(OFS_MASK):   sel = SEL_MASK;
      ADDR_W'(OFS_SIG_A):  sel = SEL_SIG_A;
      ADDR_W'(OFS_SIG_B):  sel = SEL_SIG_B;
      ADDR_W'(OFS_VER):    sel = SEL_VER;
      ADDR_W'(OFS_SIG_C):  sel = SEL_SIG_C;
      ADDR_W'(OFS_MODRST): sel = SEL_MODRST;
      ADDR_W'(OFS_BID):    sel = SEL_BID;
      default:             sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q    <= '0;
      modrst_q <= '0;
      ack_q    <= '0;
      mask_q   <= '1;
    end else if (bus_wr) begin
      case (sel)
        SEL_LED:    led_q    <= bus_wdata;
        SEL_MODRST: modrst_q <= bus_wdata;
        SEL_ACK:    ack_q    <= bus_wdata[LINES-1:0];
        SEL_MASK:   mask_q   <= bus_wdata[LINES-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_LED:    rd_val = led_q;
      SEL_STATUS: rd_val = DATA_W'(status);
      SEL_ACK:    rd_val = DATA_W'(ack_q);
      SEL_MASK:   rd_val = DATA_W'(mask_q);
      SEL_SIG_A:  rd_val = DATA_W'(SIG_A_VAL);
      SEL_SIG_B:  rd_val = DATA_W'(SIG_B_VAL);
      SEL_VER:    rd_val = DATA_W'(VERSION);
      SEL_SIG_C:  rd_val = DATA_W'(SIG_C_VAL);
      SEL_MODRST: rd_val = modrst_q;
      SEL_BID:    rd_val = DATA_W'(BOARD_ID);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign ack_bits  = ack_q;
  assign mask_bits = mask_q;
  assign led       = led_q;
  assign mod_rst   = modrst_q;

  // R8: an unmapped read returns zero on the next edge
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> (rdata_q == '0));

  // R6: read data holds when no read is issued
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q));

  // R2: the mask comes out of reset fully set
  p_mask_reset_r2: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == {LINES{1'b1}}));

  // R8: a write that selects no writable register leaves the mask alone
  p_ro_write_keeps_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel != SEL_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/cpld_irq_hub.sv
module cpld_irq_hub #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 8,
  parameter int          LINES    = 16,
  parameter logic [15:0] VERSION  = 16'h0001,
  parameter logic [15:0] BOARD_ID = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_src,
  output logic              irq_n,
  output logic [DATA_W-1:0] led_out,
  output logic [DATA_W-1:0] mod_rst_out
);

  logic [LINES-1:0] level_s;
  logic [LINES-1:0] status_w;
  logic [LINES-1:0] ack_w;
  logic [LINES-1:0] mask_w;

  cih_sync #(.WIDTH(LINES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (irq_src),
    .dout (level_s)
  );

  cih_irq_core #(.LINES(LINES)) u_core (
    .clk       (clk),
    .rst       (rst),
    .level     (level_s),
    .ack_bits  (ack_w),
    .mask_bits (mask_w),
    .status    (status_w),
    .irq_n     (irq_n)
  );

  cih_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LINES    (LINES),
    .VERSION  (VERSION),
    .BOARD_ID (BOARD_ID)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status    (status_w),
    .ack_bits  (ack_w),
    .mask_bits (mask_w),
    .led       (led_out),
    .mod_rst   (mod_rst_out)
  );

endmodule

// File: tb/cpld_irq_hub_bench.sv
module cpld_irq_hub_bench;

  localparam int          DW  = 16;
  localparam int          AW  = 8;
  localparam int          NL  = 16;
  localparam logic [15:0] VER = 16'h0102;
  localparam logic [15:0] BID = 16'h3C51;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NL-1:0] irq_src = '0;
  logic          irq_n;
  logic [DW-1:0] led_out;
  logic [DW-1:0] mod_rst_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic [15:0] m_led, m_stat, m_ack, m_mask, m_mr;

  always #10 clk = ~clk;

  cpld_irq_hub #(
    .DATA_W(DW), .ADDR_W(AW), .LINES(NL), .VERSION(VER), .BOARD_ID(BID)
  ) u_cpld_irq_hub (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_n(irq_n), .led_out(led_out),
    .mod_rst_out(mod_rst_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] model(input int a);
    case (a)
      'h00: model = m_led;
      'h10: model = m_stat;
      'h20: model = m_ack;
      'h38: model = m_mask;
      'h40: model = 16'hAAAA;
      'h48: model = 16'h5555;
      'h50: model = VER;
      'h58: model = 16'hCAFE;
      'h60: model = m_mr;
      'h68: model = BID;
      default: model = 16'h0000;
    endcase
  endfunction

  function automatic bit writable(input int a);
    writable = (a == 'h00) || (a == 'h20) || (a == 'h38) || (a == 'h60);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic [15:0] held;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);

    // R2 reset state
    check("R2 irq_n after reset", irq_n, 1);
    check("R2 led_out after reset", led_out, 0);
    check("R2 mod_rst_out after reset", mod_rst_out, 0);
    bus_read('h38, rv); check("R2 mask reset", rv, 16'hFFFF);
    bus_read('h10, rv); check("R2 status reset", rv, 0);
    bus_read('h20, rv); check("R2 ack reset", rv, 0);
    bus_read('h00, rv); check("R2 led reset", rv, 0);
    bus_read('h60, rv); check("R2 modrst reset", rv, 0);

    // R1 identification words
    bus_read('h40, rv); check("R1 sig A", rv, 16'hAAAA);
    bus_read('h48, rv); check("R1 sig B", rv, 16'h5555);
    bus_read('h58, rv); check("R1 sig C", rv, 16'hCAFE);
    bus_read('h50, rv); check("R1 version", rv, VER);
    bus_read('h68, rv); check("R1 board id", rv, BID);

    // R7 read/write registers
    bus_write('h00, 16'h1234);
    bus_write('h60, 16'h00A5);
    bus_write('h38, 16'hFFFF);
    m_led = 16'h1234; m_mr = 16'h00A5; m_mask = 16'hFFFF; m_ack = 0; m_stat = 0;
    check("R7 led_out", led_out, 16'h1234);
    check("R7 mod_rst_out", mod_rst_out, 16'h00A5);

    // R6 read latency and hold
    bus_read('h00, rv); check("R6 read value", rv, 16'h1234);
    @(negedge clk); bus_addr = AW'('h40);
    wait_cyc(2);
    check("R6 rdata holds without read", bus_rdata, 16'h1234);

    // R8 writes to every non-writable offset are ignored
    for (int a = 0; a < 256; a++) begin
      if (!writable(a)) bus_write(a, 16'hFFFF);
    end
    check("R8 led_out after stray writes", led_out, 16'h1234);
    check("R8 mod_rst_out after stray writes", mod_rst_out, 16'h00A5);
    check("R8 irq_n after stray writes", irq_n, 1);
    // R8 and R1 full address sweep against the model
    for (int a = 0; a < 256; a++) begin
      bus_read(a, rv);
      check($sformatf("R8 sweep offset 0x%02h", a), rv, model(a));
    end

    // R3 R4 R5 per-line sweep
    for (int i = 0; i < NL; i++) begin
      logic [15:0] b;
      b = 16'h1 << i;
      irq_src = b;
      wait_cyc(6);
      bus_read('h10, rv); check($sformatf("R3 capture line %0d", i), rv, b);
      check($sformatf("R5 masked line %0d irq_n", i), irq_n, 1);
      bus_write('h38, ~b);
      wait_cyc(3);
      check($sformatf("R5 unmasked line %0d irq_n", i), irq_n, 0);
      bus_write('h38, 16'hFFFF ^ (16'h1 << ((i + 1) % NL)));
      wait_cyc(3);
      check($sformatf("R5 other line unmasked %0d irq_n", i), irq_n, 1);
      bus_write('h38, ~b);
      irq_src = '0;
      wait_cyc(6);
      bus_read('h10, rv); check($sformatf("R3 sticky line %0d", i), rv, b);
      check($sformatf("R5 sticky line %0d irq_n", i), irq_n, 0);
      irq_src = b;
      bus_write('h20, b);
      wait_cyc(3);
      bus_read('h10, rv); check($sformatf("R4 held clear line %0d", i), rv, 0);
      check($sformatf("R4 held clear line %0d irq_n", i), irq_n, 1);
      bus_write('h20, 16'h0);
      wait_cyc(6);
      bus_read('h10, rv); check($sformatf("R4 reset line %0d", i), rv, b);
      irq_src = '0;
      wait_cyc(4);
      bus_write('h20, 16'hFFFF);
      bus_write('h20, 16'h0);
      wait_cyc(2);
      bus_read('h10, rv); check($sformatf("R4 clear all line %0d", i), rv, 0);
      bus_write('h38, 16'hFFFF);
    end

    // R5 multi-line pattern with selective mask
    irq_src = 16'h001F;
    wait_cyc(6);
    irq_src = '0;
    bus_read('h10, rv); check("R3 pattern capture", rv, 16'h001F);
    bus_write('h38, 16'hFFE0);
    wait_cyc(3);
    check("R5 pattern lines unmasked, none pending outside", irq_n, 0);
    bus_write('h20, 16'h000F);
    bus_write('h20, 16'h0000);
    wait_cyc(3);
    bus_read('h10, rv); check("R4 partial ack", rv, 16'h0010);
    check("R5 line 4 still pending", irq_n, 0);
    bus_write('h38, 16'hFFEF ^ 16'h0010 ^ 16'h0001);
    wait_cyc(3);
    check("R5 line 4 masked, line 0 empty", irq_n, 1);
    bus_read('h20, rv); check("R7 ack readback", rv, 0);
    bus_read('h38, rv); check("R7 mask readback", rv, 16'hFFFE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule